// File: doc/BRIEF.md
# Dual-Scheme Serial Clock Generator

This block derives a serial shift clock from the module clock. A single configuration word carries two divisor fields and a bit that picks between them. The linear scheme holds each clock level for N+1 module-clock cycles. The power-of-two scheme holds each level for 2^M cycles. Either way the output has a 50% duty cycle. Working out which field values give a wanted bit rate is left to software.

While the enable is low, the clock sits at a programmable idle level and the internal count is held at zero. When the enable is raised, the block starts a fresh period. Alongside the clock it emits two single-cycle strobes: one when the clock leaves its idle level and one when it returns to it. A neighbouring shift register uses these strobes to know when to launch and when to capture data. A new configuration word written during a run is picked up only when the current period ends, so no shortened or stretched half-period ever appears on the pin.

Top module: `sclk_dual_div`

## Requirements
- R1: With bit 12 of the configuration word at 1, the linear field in bits [7:0] (value N) sets every clock level to last N+1 module-clock cycles, so one period is 2*(N+1) cycles. N = 0 toggles the clock on every module-clock edge, which is half the module-clock rate.
- R2: With bit 12 at 0, the exponent field in bits [11:8] (value M) sets every clock level to last 2^M module-clock cycles, so one period is 2^(M+1) cycles. This holds for every M from 0 to 15.
- R3: The field that the select bit does not pick has no effect on the clock or on the strobes.
- R4: While the enable is low, the clock output equals the idle-level input, with no clock edge needed to get there, and both strobes stay low. If the enable is first seen high at edge 1, the first clock transition happens at edge H, where H is the half-period in module-clock cycles.
- R5: The leading strobe is high for exactly the one cycle in which the clock has just left its idle level. The trailing strobe is high for exactly the one cycle in which the clock has just returned to idle. The two strobes are never high together.
- R6: A configuration change made during a run takes effect only after the next return to idle. The first period after the enable rises uses the word that was present while the enable was low.
- R7: The clock output is the idle level XOR the active phase. With an idle level of 1, the leading transition is a falling edge and the trailing transition is a rising edge.
- R8: Dropping the enable part-way through a period and raising it again restarts the count from zero. The next first transition then follows the R4 timing.
- R9: During reset and after it is released, the clock is at the idle level and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Run enable; low holds the clock at idle and clears the count |
| idle_lvl_i | input | 1 | Level of the clock while idle (clock polarity) |
| div_cfg_i | input | 13 | [7:0] linear divisor N, [11:8] exponent M, [12] scheme select (1 = linear) |
| sclk_o | output | 1 | Generated serial clock |
| lead_o | output | 1 | One-cycle strobe when the clock leaves idle |
| trail_o | output | 1 | One-cycle strobe when the clock returns to idle |

## Verification
The bench sweeps the linear divisor from 0 to 63 and also tests 255. It sweeps the exponent from 0 to 13 and adds single long runs at 14 and 15. This catches an off-by-one in the half-period: such a design would show its first transition one cycle early or late. It also catches an exponent decode that wraps at the widest setting, which would run far too fast at M = 15. The unused field is loaded with changing junk throughout the sweep, so a design that mixes the two fields produces the wrong period. A configuration change in the middle of a period checks the period-boundary rule: a design that loads the new word at once shows a half-period of the wrong length. An abort-and-restart sequence catches a count that is not cleared, which would make the first transition after restart come early. Runs at both idle levels catch strobes that are tied to rising or falling edges instead of to leaving and returning to idle.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  // Scheme select encoding, bit 12 of the configuration word
  typedef enum logic {
    SCHEME_POW2 = 1'b0,
    SCHEME_LIN  = 1'b1
  } scheme_e;

  // Width needed to hold the terminal count (half-period minus one)
  function automatic int term_width(input int lin_w, input int exp_w);
    int pow_w;
    pow_w = (1 << exp_w) - 1;
    return (lin_w > pow_w) ? lin_w : pow_w;
  endfunction

endpackage

// File: rtl/sclk_div_term.sv
// Decodes the configuration fields into a terminal count (half-period - 1).
module sclk_div_term
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 15
) (
  input  logic             sel_lin_i,
  input  logic [LIN_W-1:0] lin_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [CNT_W-1:0] term_o
);

  logic [CNT_W-1:0] lin_term;
  logic [CNT_W-1:0] pow_term;

  assign lin_term = CNT_W'(lin_i);

  // 2^M - 1 is a thermometer code: bit g is set when g < M
  for (genvar g = 0; g < CNT_W; g++) begin : g_thermo
    assign pow_term[g] = (32'(exp_i) > g);
  end

  always_comb begin
    if (scheme_e'(sel_lin_i) == SCHEME_LIN) term_o = lin_term;
    else                                    term_o = pow_term;
  end

endmodule

// File: rtl/sclk_div_hold.sv
// Holds the active terminal count; reloads only while idle or at period end.
module sclk_div_hold #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             period_end_i,
  input  logic [CNT_W-1:0] term_new_i,
  output logic [CNT_W-1:0] term_o
);

  logic             load;
  logic [CNT_W-1:0] term_q;

  assign load = !en_i || period_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   term_q <= '0;
    else if (load) term_q <= term_new_i;
  end

  assign term_o = term_q;

endmodule

// File: rtl/sclk_div_core.sv
// Half-period counter, phase toggle and edge strobes.
module sclk_div_core #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             phase_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             period_end_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             lead_q, lead_d;
  logic             trail_q, trail_d;
  logic             at_term;

  assign at_term = (cnt_q == term_i);

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    phase_d = phase_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (!en_i) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (at_term) begin
      cnt_d   = '0;
      phase_d = !phase_q;
      lead_d  = !phase_q;
      trail_d = phase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign period_end_o = en_i && at_term && phase_q;
  assign phase_o      = phase_q;
  assign lead_o       = lead_q;
  assign trail_o      = trail_q;
  assign cnt_o        = cnt_q;

  assert_one_cycle_lead_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |=> !lead_q);

  assert_one_cycle_trail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_q |=> !trail_q);

endmodule

// File: rtl/sclk_dual_div.sv
module sclk_dual_div
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             idle_lvl_i,
  input  logic [CFG_W-1:0] div_cfg_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);

  localparam int CNT_W = term_width(LIN_W, EXP_W);
  localparam int SEL_B = LIN_W + EXP_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [CNT_W-1:0] term_new, term_act, cnt;
  logic             phase, period_end;

  sclk_div_term #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) term_i (
    .sel_lin_i (div_cfg_i[SEL_B]),
    .lin_i     (div_cfg_i[LIN_W-1:0]),
    .exp_i     (div_cfg_i[SEL_B-1:LIN_W]),
    .term_o    (term_new)
  );

  sclk_div_hold #(
    .CNT_W (CNT_W)
  ) hold_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .en_i         (en_i),
    .period_end_i (period_end),
    .term_new_i   (term_new),
    .term_o       (term_act)
  );

  sclk_div_core #(
    .CNT_W (CNT_W)
  ) core_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .en_i         (en_i),
    .term_i       (term_act),
    .phase_o      (phase),
    .lead_o       (lead_o),
    .trail_o      (trail_o),
    .period_end_o (period_end),
    .cnt_o        (cnt)
  );

  assign sclk_o = idle_lvl_i ^ phase;

  // Counter never passes the terminal value held in the other block
  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt <= term_act);

  assert_idle_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> (sclk_o == idle_lvl_i) && !lead_o && !trail_o);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(lead_o && trail_o));

  assert_lead_level_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    lead_o |-> (sclk_o != idle_lvl_i));

  assert_trail_level_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    trail_o |-> (sclk_o == idle_lvl_i));

  // Active divisor only moves at a period boundary or while stopped
  assert_term_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(term_act) |-> (trail_o || !$past(en_i)));

endmodule

// File: tb/sclk_dual_div_tb_top.sv
module sclk_dual_div_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        idle;
  logic [12:0] cfg;
  logic        sclk, lead, trail;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = !clk;

  sclk_dual_div dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .idle_lvl_i (idle),
    .div_cfg_i  (cfg),
    .sclk_o     (sclk),
    .lead_o     (lead),
    .trail_o    (trail)
  );

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk_idle(input logic pol, input string tag);
    checks++;
    if (sclk !== pol || lead !== 1'b0 || trail !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: sclk/lead/trail=%b%b%b expected %b00", tag, sclk, lead, trail, pol);
    end
  endtask

  // Expected outputs e edges after the enable was first seen, half-period h
  task automatic expect_edge(input int e, input int h, input logic pol, input string tag);
    int   k  = e / h;
    int   r  = e % h;
    logic ep = k[0];
    logic el = (r == 0) && k[0];
    logic et = (r == 0) && !k[0] && (k > 0);
    checks++;
    if (sclk !== (ep ^ pol) || lead !== el || trail !== et) begin
      errors++;
      $display("FAIL %s e=%0d h=%0d: sclk/lead/trail=%b%b%b expected %b%b%b",
               tag, e, h, sclk, lead, trail, ep ^ pol, el, et);
    end
  endtask

  task automatic run_cfg(input logic lin, input int n, input int m, input logic pol,
                         input int h, input int edges, input string tag);
    @(negedge clk);
    en   = 1'b0;
    cfg  = {lin, 4'(m), 8'(n)};
    idle = pol;
    @(negedge clk);
    chk_idle(pol, "R4");
    en = 1'b1;
    for (int e = 1; e <= edges; e++) begin
      @(negedge clk);
      expect_edge(e, h, pol, tag);
    end
    en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    idle  = 1'b1;
    cfg   = '0;
    repeat (3) @(negedge clk);
    chk_idle(1'b1, "R9");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle(1'b1, "R9");

    // R4 / R7: idle level followed without a clock edge while stopped
    idle = 1'b0; #1; chk_idle(1'b0, "R4");
    idle = 1'b1; #1; chk_idle(1'b1, "R7");

    // R1 and R3: linear sweep, exponent field filled with junk
    for (int n = 0; n < 64; n++)
      run_cfg(1'b1, n, (n ^ 10) & 15, n[0], n + 1, 4 * (n + 1), "R1/R3");
    run_cfg(1'b1, 255, 15, 1'b0, 256, 1024, "R1");

    // R2 and R3: power-of-two sweep, linear field filled with junk
    for (int m = 0; m < 14; m++)
      run_cfg(1'b0, 255 - 17 * m, m, m[0], 1 << m, 4 * (1 << m), "R2/R3");
    run_cfg(1'b0, 3, 14, 1'b1, 1 << 14, (1 << 14) + 1, "R2");
    run_cfg(1'b0, 0, 15, 1'b0, 1 << 15, 2 * (1 << 15) + 1, "R2");

    // R6: change from half-period 4 to 2 in the middle of the first period
    @(negedge clk);
    en = 1'b0; idle = 1'b0; cfg = {1'b1, 4'd0, 8'd3};
    @(negedge clk);
    en = 1'b1;
    for (int e = 1; e <= 16; e++) begin
      @(negedge clk);
      if (e <= 8) expect_edge(e, 4, 1'b0, "R6");
      else        expect_edge(e - 8, 2, 1'b0, "R6");
      if (e == 2) cfg = {1'b1, 4'd0, 8'd1};
    end

    // R8: abort mid-period, restart from zero
    @(negedge clk);
    en = 1'b0; idle = 1'b1; cfg = {1'b1, 4'd0, 8'd2};
    @(negedge clk);
    en = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      expect_edge(e, 3, 1'b1, "R8");
    end
    en = 1'b0;
    @(negedge clk);
    chk_idle(1'b1, "R8");
    en = 1'b1;
    for (int e = 1; e <= 12; e++) begin
      @(negedge clk);
      expect_edge(e, 3, 1'b1, "R8");
    end
    en = 1'b0;
    @(negedge clk);
    chk_idle(1'b1, "R5");

    report();
  end

endmodule